// File: doc/BRIEF.md
# Nested-Loop Microprogram Sequencer

This block keeps a microprogram in an on-chip instruction store and steps through it one word per clock. It broadcasts every compute word, unchanged and in the same cycle, to a set of processing-element lanes. Looping is done in hardware. Each nesting level has its own iteration counter and its own return-address register. A counted branch tests the counter, jumps and decrements it in a single cycle. A compute word can carry the same branch action, so the last instruction of a loop body costs no extra cycle.

The block has two operating modes, selected by one run input. While the input is low the sequencer is idle and a host may write the instruction store. When the input goes high the program counter returns to zero and the program runs until a halt word is reached. The sequencer then reports halted and stays there until the run input is dropped. Dropping the run input at any time returns the block to idle on the next edge.

Top module: `ucode_seq`

## Requirements
- R1: After reset, and in every cycle that follows a clock edge at which run_i was low, uop_valid_o is all zeros and halted_o is 0.
- R2: On the edge that first samples run_i high after idle, the program counter is cleared to address 0 and nothing is issued. The word at address 0 is executed on the following edge.
- R3: Instruction word (48 bits): bits [47:45] hold the opcode, with 0 nop, 1 halt, 2 loop-set, 3 branch-if-nonzero and 4 compute (5 to 7 act as nop). Bit [44] is the fuse bit. Bits [43:42] select the loop level, bits [41:29] hold the jump target and bits [15:0] hold the count. When a compute word executes, the whole word appears on uop_o with uop_valid_o set, one cycle later. Nop, loop-set, branch and halt words issue nothing.
- R4: Loop-set writes its count into the counter of the selected level and its target into that level's jump register, then continues at the next address.
- R5: Branch-if-nonzero on a level whose counter is not zero jumps to that level's jump register and decrements the counter in the same cycle. On a zero counter it falls through to the next address and the counter stays at zero. A body closed by such a branch therefore runs count+1 times.
- R6: A compute word with the fuse bit set is issued and performs the branch action of R5 in the same cycle.
- R7: Four loop levels exist. Loop-set and branch act only on the level they select, so an outer loop's count survives the inner loop's activity.
- R8: A halt word stops execution. halted_o rises one cycle later and stays high with nothing issued for as long as run_i stays high.
- R9: Host writes to the instruction store take effect only while the sequencer is idle. A write made while running or halted leaves the program unchanged.
- R10: Lowering run_i while a program runs stops issue at the next edge and returns the block to idle.
- R11: Every lane of uop_o carries the same word, and every bit of uop_valid_o has the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High selects computing mode, low selects idle mode |
| wr_en_i | input | 1 | Host write strobe for the instruction store |
| wr_addr_i | input | PC_W (10) | Host write address |
| wr_data_i | input | 48 | Host write data (instruction word) |
| halted_o | output | 1 | The program has executed a halt word |
| uop_valid_o | output | NLANES (4) | Per-lane valid for the issued word |
| uop_o | output | NLANES*48 (192) | Issued word, one 48-bit slice per lane |

## Verification
The checker takes for granted that run_i has a defined level at every edge after reset. It also assumes host writes are meant only for idle time. It makes no assumption about program content, so halt, issue and lane agreement are checked in every cycle whatever the store holds. The stimulus changes run_i and the write port only at falling edges. It loads each program fully while idle and fills every address the program can reach. It makes exactly one write outside idle, which is the deliberate write for the R9 check.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

   // Instruction word geometry (fixed; the lanes and host see the same word)
   localparam int INSN_W   = 48;
   localparam int OP_LO    = 45;
   localparam int OP_W     = 3;
   localparam int FUSE_BIT = 44;
   localparam int LVL_LO   = 42;
   localparam int LVL_W    = 2;
   localparam int TGT_LO   = 29;
   localparam int TGT_W    = 13;
   localparam int CNT_LO   = 0;
   localparam int CNT_W    = 16;
   localparam int MAX_LEVELS = 1 << LVL_W;

   typedef enum logic [OP_W-1:0] {
      OPC_NOP  = 3'd0,
      OPC_HALT = 3'd1,
      OPC_LSET = 3'd2,
      OPC_BNZ  = 3'd3,
      OPC_COMP = 3'd4
   } opcode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HALT = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic halt;
      logic lset;
      logic branch;
      logic issue;
   } ctl_t;

endpackage

// File: rtl/ucode_store.sv
module ucode_store #(
   parameter int DEPTH = 1024,
   parameter int WIDTH = 48,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/ucode_decode.sv
module ucode_decode
   import ucode_pkg::*;
(
   input  logic [OP_W-1:0] op,
   input  logic            fuse,
   output ctl_t            ctl
);

   always_comb begin
      ctl = '0;
      unique case (op)
         OPC_HALT: ctl.halt   = 1'b1;
         OPC_LSET: ctl.lset   = 1'b1;
         OPC_BNZ:  ctl.branch = 1'b1;
         OPC_COMP: begin
            ctl.issue  = 1'b1;
            ctl.branch = fuse;
         end
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/ucode_loops.sv
module ucode_loops
   import ucode_pkg::*;
#(
   parameter int LEVELS = 4,
   parameter int PC_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic             br_en,
   input  logic [LVL_W-1:0] lvl,
   input  logic [CNT_W-1:0] set_cnt,
   input  logic [PC_W-1:0]  set_tgt,
   output logic             take,
   output logic [PC_W-1:0]  jump
);

   logic [CNT_W-1:0] cnt_q [LEVELS];
   logic [PC_W-1:0]  tgt_q [LEVELS];
   logic [LEVELS-1:0] sel;

   for (genvar g = 0; g < LEVELS; g++) begin : g_level
      assign sel[g] = (lvl == LVL_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q[g] <= '0;
            tgt_q[g] <= '0;
         end else if (sel[g]) begin
            if (set_en) begin
               cnt_q[g] <= set_cnt;
               tgt_q[g] <= set_tgt;
            end else if (br_en && (cnt_q[g] != '0)) begin
               cnt_q[g] <= cnt_q[g] - 1'b1;
            end
         end
      end
   end

   always_comb begin
      take = 1'b0;
      jump = '0;
      for (int i = 0; i < LEVELS; i++) begin
         if (sel[i]) begin
            take = br_en && (cnt_q[i] != '0);
            jump = tgt_q[i];
         end
      end
   end

endmodule

// File: rtl/ucode_fanout.sv
module ucode_fanout #(
   parameter int NLANES = 4,
   parameter int WIDTH  = 48
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_in,
   input  logic [WIDTH-1:0]        dat_in,
   output logic [NLANES-1:0]       vld_out,
   output logic [NLANES*WIDTH-1:0] dat_out
);

   for (genvar l = 0; l < NLANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_out[l]                 <= 1'b0;
            dat_out[l*WIDTH +: WIDTH]  <= '0;
         end else begin
            vld_out[l] <= vld_in;
            if (vld_in) begin
               dat_out[l*WIDTH +: WIDTH] <= dat_in;
            end
         end
      end
   end

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
   import ucode_pkg::*;
#(
   parameter int DEPTH  = 1024,
   parameter int LEVELS = 4,
   parameter int NLANES = 4,
   localparam int PC_W  = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run_i,
   input  logic                     wr_en_i,
   input  logic [PC_W-1:0]          wr_addr_i,
   input  logic [INSN_W-1:0]        wr_data_i,
   output logic                     halted_o,
   output logic [NLANES-1:0]        uop_valid_o,
   output logic [NLANES*INSN_W-1:0] uop_o
);

   // Elaboration-time parameter checks
   if (DEPTH < 2 || (1 << PC_W) != DEPTH) begin : g_bad_depth
      $error("ucode_seq: DEPTH must be a power of two and at least 2");
   end
   if (PC_W > TGT_W) begin : g_bad_tgt
      $error("ucode_seq: DEPTH exceeds the jump-target field");
   end
   if (LEVELS < 1 || LEVELS > MAX_LEVELS) begin : g_bad_lvl
      $error("ucode_seq: LEVELS out of range for the level field");
   end
   if (NLANES < 1) begin : g_bad_lanes
      $error("ucode_seq: NLANES must be at least 1");
   end

   seq_state_e        state_q;
   logic [PC_W-1:0]   pc_q;
   logic [PC_W-1:0]   pc_next;
   logic [INSN_W-1:0] insn;
   ctl_t              ctl;
   logic              exec;
   logic              take;
   logic [PC_W-1:0]   jump;

   ucode_store #(.DEPTH(DEPTH), .WIDTH(INSN_W)) u_store (
      .clk   (clk),
      .we    (wr_en_i && (state_q == ST_IDLE) && !run_i),
      .waddr (wr_addr_i),
      .wdata (wr_data_i),
      .raddr (pc_q),
      .rdata (insn)
   );

   ucode_decode u_dec (
      .op   (insn[OP_LO +: OP_W]),
      .fuse (insn[FUSE_BIT]),
      .ctl  (ctl)
   );

   assign exec = run_i && (state_q == ST_RUN);

   ucode_loops #(.LEVELS(LEVELS), .PC_W(PC_W)) u_loops (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (exec && ctl.lset),
      .br_en   (exec && ctl.branch),
      .lvl     (insn[LVL_LO +: LVL_W]),
      .set_cnt (insn[CNT_LO +: CNT_W]),
      .set_tgt (insn[TGT_LO +: PC_W]),
      .take    (take),
      .jump    (jump)
   );

   assign pc_next = take ? jump : pc_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
      end else if (!run_i) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               state_q <= ST_RUN;
               pc_q    <= '0;
            end
            ST_RUN: begin
               if (ctl.halt) state_q <= ST_HALT;
               else          pc_q    <= pc_next;
            end
            ST_HALT: state_q <= ST_HALT;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign halted_o = (state_q == ST_HALT);

   ucode_fanout #(.NLANES(NLANES), .WIDTH(INSN_W)) u_fan (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_in  (exec && ctl.issue),
      .dat_in  (insn),
      .vld_out (uop_valid_o),
      .dat_out (uop_o)
   );

endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk
   import ucode_pkg::*;
#(
   parameter int NLANES = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     run_i,
   input logic                     halted_o,
   input logic [NLANES-1:0]        uop_valid_o,
   input logic [NLANES*INSN_W-1:0] uop_o
);

   // R1 / R10: a low run input empties the output and clears halted
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (uop_valid_o == '0 && !halted_o));

   // R2: the edge that leaves idle issues nothing
   p_start_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !$past(run_i) && !halted_o) |=> (uop_valid_o == '0));

   // R8: halted is held while running and nothing is issued
   p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_o && run_i) |=> halted_o);

   p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |-> (uop_valid_o == '0));

   // R11: lanes agree
   p_lane_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid_o == '0) || (uop_valid_o == '1));

   for (genvar l = 1; l < NLANES; l++) begin : g_lane_chk
      p_lane_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
         uop_valid_o[l] |-> (uop_o[l*INSN_W +: INSN_W] == uop_o[INSN_W-1:0]));
   end

endmodule

bind ucode_seq ucode_seq_chk #(.NLANES(NLANES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run_i       (run_i),
   .halted_o    (halted_o),
   .uop_valid_o (uop_valid_o),
   .uop_o       (uop_o)
);

// File: tb/ucode_seq_test.sv
module ucode_seq_test;
   import ucode_pkg::*;

   localparam int DEPTH  = 1024;
   localparam int NLANES = 4;
   localparam int PC_W   = $clog2(DEPTH);

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     run_i = 1'b0;
   logic                     wr_en_i = 1'b0;
   logic [PC_W-1:0]          wr_addr_i = '0;
   logic [INSN_W-1:0]        wr_data_i = '0;
   logic                     halted_o;
   logic [NLANES-1:0]        uop_valid_o;
   logic [NLANES*INSN_W-1:0] uop_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit mon_en  = 1'b0;
   logic [INSN_W-1:0] exp_q [$];

   always #10 clk = ~clk;   // 50 MHz

   ucode_seq #(.DEPTH(DEPTH), .LEVELS(4), .NLANES(NLANES)) uut (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .halted_o(halted_o),
      .uop_valid_o(uop_valid_o), .uop_o(uop_o)
   );

   // ---------------- word builders (encoding of R3) ----------------
   function automatic logic [INSN_W-1:0] w_comp(input logic [15:0] tag,
                                                input bit fuse, input int lvl);
      logic [INSN_W-1:0] w = '0;
      w[47:45] = 3'd4; w[44] = fuse; w[43:42] = 2'(lvl); w[15:0] = tag;
      w[28:20] = 9'h15A;
      return w;
   endfunction
   function automatic logic [INSN_W-1:0] w_lset(input int lvl, input int tgt, input int cnt);
      logic [INSN_W-1:0] w = '0;
      w[47:45] = 3'd2; w[43:42] = 2'(lvl); w[41:29] = 13'(tgt); w[15:0] = 16'(cnt);
      return w;
   endfunction
   function automatic logic [INSN_W-1:0] w_bnz(input int lvl);
      logic [INSN_W-1:0] w = '0;
      w[47:45] = 3'd3; w[43:42] = 2'(lvl);
      return w;
   endfunction
   function automatic logic [INSN_W-1:0] w_halt();
      logic [INSN_W-1:0] w = '0;
      w[47:45] = 3'd1;
      return w;
   endfunction
   function automatic logic [INSN_W-1:0] w_nop();
      return '0;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic load(input int addr, input logic [INSN_W-1:0] data);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = PC_W'(addr); wr_data_i = data;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   // ---------------- scoreboard monitor ----------------
   always @(negedge clk) begin
      if (mon_en && uop_valid_o != '0) begin
         logic [INSN_W-1:0] e;
         if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected issue", 64'(uop_o[INSN_W-1:0]), 64'h0);
         end else begin
            e = exp_q.pop_front();
            check(uop_valid_o == '1, "R11", "lane valids", 64'(uop_valid_o), 64'hF);
            for (int l = 0; l < NLANES; l++) begin
               check(uop_o[l*INSN_W +: INSN_W] == e, "R3", "issued word",
                     64'(uop_o[l*INSN_W +: INSN_W]), 64'(e));
            end
         end
      end
   end

   // Run a loaded program with the expectations already queued
   task automatic run_prog(input string req);
      int guard;
      @(negedge clk);
      run_i  = 1'b1;
      mon_en = 1'b1;
      @(negedge clk);
      check(uop_valid_o == '0, "R2", "no issue on start edge", 64'(uop_valid_o), 64'h0);
      guard = 0;
      while (!halted_o && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      check(halted_o == 1'b1, "R8", "halted reached", 64'(halted_o), 64'h1);
      check(exp_q.size() == 0, req, "all expected words issued", 64'(exp_q.size()), 64'h0);
      repeat (3) @(negedge clk);
      check(halted_o == 1'b1 && uop_valid_o == '0, "R8", "halt held quietly",
            64'({halted_o, uop_valid_o}), 64'h10);
   endtask

   task automatic stop_run();
      @(negedge clk);
      run_i = 1'b0;
      @(negedge clk);
      check(halted_o == 1'b0 && uop_valid_o == '0, "R1", "idle after run low",
            64'({halted_o, uop_valid_o}), 64'h0);
      mon_en = 1'b0;
      exp_q.delete();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(halted_o == 1'b0, "R1", "halted after reset", 64'(halted_o), 64'h0);
      check(uop_valid_o == '0, "R1", "valid after reset", 64'(uop_valid_o), 64'h0);

      // Straight-line program: compute, nop, compute, halt (R3, R8)
      load(0, w_comp(16'hA001, 0, 0));
      load(1, w_nop());
      load(2, w_comp(16'hA002, 0, 0));
      load(3, w_halt());
      exp_q.push_back(w_comp(16'hA001, 0, 0));
      exp_q.push_back(w_comp(16'hA002, 0, 0));
      run_prog("R3");

      // R9: write during halt is ignored; rerun restarts at 0 (R2)
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = '0; wr_data_i = w_halt();
      @(negedge clk);
      wr_en_i = 1'b0;
      stop_run();
      exp_q.push_back(w_comp(16'hA001, 0, 0));
      exp_q.push_back(w_comp(16'hA002, 0, 0));
      run_prog("R9");
      stop_run();

      // Single loop, count 2 -> body three times (R4, R5)
      load(0, w_lset(0, 1, 2));
      load(1, w_comp(16'hB001, 0, 0));
      load(2, w_bnz(0));
      load(3, w_comp(16'hB002, 0, 0));
      load(4, w_halt());
      for (int i = 0; i < 3; i++) exp_q.push_back(w_comp(16'hB001, 0, 0));
      exp_q.push_back(w_comp(16'hB002, 0, 0));
      run_prog("R5");
      stop_run();

      // Nested loops with a fused branch closing the inner body (R6, R7)
      load(0, w_lset(1, 1, 1));
      load(1, w_lset(0, 2, 1));
      load(2, w_comp(16'hC001, 0, 0));
      load(3, w_comp(16'hC002, 1, 0));
      load(4, w_bnz(1));
      load(5, w_halt());
      for (int i = 0; i < 4; i++) begin
         exp_q.push_back(w_comp(16'hC001, 0, 0));
         exp_q.push_back(w_comp(16'hC002, 1, 0));
      end
      run_prog("R6");
      stop_run();

      // Zero count falls through; outer level 2 keeps its count (R5, R7)
      load(0, w_lset(2, 1, 2));
      load(1, w_lset(3, 2, 0));
      load(2, w_comp(16'hD001, 0, 0));
      load(3, w_bnz(3));
      load(4, w_comp(16'hD002, 0, 0));
      load(5, w_bnz(2));
      load(6, w_halt());
      for (int i = 0; i < 3; i++) begin
         exp_q.push_back(w_comp(16'hD001, 0, 0));
         exp_q.push_back(w_comp(16'hD002, 0, 0));
      end
      run_prog("R7");
      stop_run();

      // Abort a long loop by dropping run (R10)
      load(0, w_lset(2, 1, 1000));
      load(1, w_comp(16'hE001, 0, 0));
      load(2, w_bnz(2));
      load(3, w_halt());
      @(negedge clk);
      run_i = 1'b1;
      repeat (20) @(negedge clk);
      // pattern alternates issue / branch, so look over two cycles
      begin
         bit seen = 1'b0;
         for (int i = 0; i < 2; i++) begin
            if (uop_valid_o == '1 && uop_o[15:0] == 16'hE001) seen = 1'b1;
            @(negedge clk);
         end
         check(seen, "R3", "loop issuing before abort", 64'(seen), 64'h1);
      end
      run_i = 1'b0;
      @(negedge clk);
      check(uop_valid_o == '0 && halted_o == 1'b0, "R10", "abort stops issue",
            64'({halted_o, uop_valid_o}), 64'h0);
      repeat (3) @(negedge clk);
      check(uop_valid_o == '0, "R10", "stays idle", 64'(uop_valid_o), 64'h0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule